// File: doc/BRIEF.md
# Left-justified serial audio receiver

This block receives a two-channel serial audio stream in left-justified format and turns each channel slot into a parallel sample. It runs on the serial bit clock. On every rising edge it samples the word clock and the data line. The word clock selects the channel: high means left, low means right. Every level change of the word clock opens a new slot. The first bit of the new slot is on the data line in the same bit period as that change, with no delay bit in front of it.

The sample is sent most significant bit first. A control input selects a word length of 16, 20 or 24 bits. The result is placed in a 24-bit field, aligned to the most significant end. Positions below the selected length are zero, and slot bits that follow the selected length are thrown away. A slot closes when the next word-clock change arrives. At that point either a one-cycle valid strobe appears on the matching channel or, if the slot was too short, a one-cycle framing-error strobe appears.

Top module: `lj_rx`

## Requirements
- R1: While `rst` is high at a rising `bclk` edge, the receiver clears both sample outputs to zero and drives `left_valid`, `right_valid` and `frame_err` low. All outputs stay at these values until the first slot closes.
- R2: A slot captured while `lrck` was high is reported on `left_data`/`left_valid`. A slot captured while `lrck` was low is reported on `right_data`/`right_valid`. The two valid strobes are never high together.
- R3: The data bit sampled on the same rising edge where a new `lrck` level is first seen is the most significant bit of the new slot, and it lands in bit 23 of the output.
- R4: The bits of a slot are sampled on rising `bclk` edges, most significant first. The k-th bit of the slot (k counted from 0) goes to output bit 23-k.
- R5: The `wlen_sel` encoding is 0 for 16 bits, 1 for 20 bits, and 2 or 3 for 24 bits. The captured sample is aligned to the most significant end, and output bits [23-L:0] are zero for word length L.
- R6: Slot bits after the first L bits have no effect on the reported sample.
- R7: A slot closes on the rising edge where the opposite `lrck` level is first sampled. If the closing slot had at least L bits, the matching valid output is high for exactly the next clock cycle and the new data appears in that same cycle. The data is then held until that channel's next valid strobe.
- R8: A slot that closes with fewer than L bits produces no valid strobe. Instead `frame_err` goes high for one cycle, and both sample outputs keep their previous values.
- R9: `wlen_sel` is sampled only when a left slot opens, and at the first slot that opens after reset. A right slot uses the length latched at the start of its frame.
- R10: After reset the slot that is already in progress is never reported. Capture begins at the first `lrck` change that is observed.
- R11: A slot longer than 32 bits still produces a correct sample. The bit counter saturates instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Word clock; high selects the left slot, low the right slot |
| sdata | input | 1 | Serial data, MSB first |
| wlen_sel | input | 2 | Word length select: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| left_data | output | 24 | Last left sample, MSB-aligned |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right sample, MSB-aligned |
| right_valid | output | 1 | One-cycle strobe for a new right sample |
| frame_err | output | 1 | One-cycle strobe for a slot shorter than the word length |

## Verification
The bench targets the following corner cases:

- **MSB alone.** A slot carries only its top bit set. A receiver that waits one bit after the word-clock change, as in I2S, would lose this bit and report zero.
- **Trailing ones at 16 and 20 bits.** Slots have ones in every bit past the word length. A design with a wrong mask would leak those bits into the low end of the sample.
- **Length change mid-frame.** The length select changes partway through a frame. A design that latched it at every slot would shorten the right sample of that frame.
- **Short and exact slots.** A slot with too few bits must raise a framing error and leave the held data untouched. A slot of exactly the word length must still be accepted, so a design with an off-by-one compare would flag it as an error.
- **Long slot.** A 40-bit slot exposes a counter that wraps instead of saturating, because the wrapped count would overwrite captured bits.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

  typedef enum logic [1:0] {
    WL_16   = 2'd0,
    WL_20   = 2'd1,
    WL_24   = 2'd2,
    WL_24_X = 2'd3
  } wlen_e;

  // Number of sample bits for a given length code.
  function automatic int unsigned wlen_bits(input logic [1:0] sel);
    case (wlen_e'(sel))
      WL_16:   return 16;
      WL_20:   return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/lj_edge_det.sv
module lj_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lrck,
  output logic slot_edge,
  output logic chan_new,
  output logic chan_old
);
  logic lr_q;
  logic primed_q;

  // First cycle after reset only records the word clock level.
  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q     <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lr_q     <= lrck;
      primed_q <= 1'b1;
    end
  end

  assign slot_edge = primed_q && (lrck != lr_q);
  assign chan_new  = lrck;
  assign chan_old  = lr_q;
endmodule

// File: rtl/lj_wlen_latch.sv
module lj_wlen_latch #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_edge,
  input  logic             chan_new,
  input  logic [1:0]       wlen_sel,
  output logic [CNT_W-1:0] wl_o
);
  import lj_rx_pkg::*;

  logic             seen_q;
  logic [CNT_W-1:0] wl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      wl_q   <= CNT_W'(DATA_W);
    end else if (slot_edge && (chan_new || !seen_q)) begin
      seen_q <= 1'b1;
      wl_q   <= CNT_W'(wlen_bits(wlen_sel));
    end
  end

  assign wl_o = wl_q;
endmodule

// File: rtl/lj_slot_cap.sv
module lj_slot_cap #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_edge,
  input  logic              sdata,
  input  logic [CNT_W-1:0]  wl_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] bit_mask;
  int                pos;

  // One-hot position of the next bit of the slot.
  always_comb begin
    pos      = int'(DATA_W) - 1 - int'(cnt_q);
    bit_mask = '0;
    if (pos >= 0)
      bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      word_q   <= '0;
    end else if (slot_edge) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
      word_q   <= {sdata, {(DATA_W-1){1'b0}}};
    end else if (active_q) begin
      if (cnt_q < wl_i && sdata)
        word_q <= word_q | bit_mask;
      if (cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign word_o   = word_q;
endmodule

// File: rtl/lj_out_stage.sv
module lj_out_stage #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_edge,
  input  logic              active_i,
  input  logic              chan_old,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  wl_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] left_data,
  output logic              left_valid,
  output logic [DATA_W-1:0] right_data,
  output logic              right_valid,
  output logic              frame_err
);
  logic closing;
  logic complete;

  assign closing  = slot_edge && active_i;
  assign complete = cnt_i >= wl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_data   <= '0;
      right_data  <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      left_valid  <= closing && complete && chan_old;
      right_valid <= closing && complete && !chan_old;
      frame_err   <= closing && !complete;
      if (closing && complete) begin
        if (chan_old) left_data  <= word_i;
        else          right_data <= word_i;
      end
    end
  end
endmodule

// File: rtl/lj_rx.sv
module lj_rx #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned SLOT_BITS = 32
) (
  input  logic              bclk,
  input  logic              rst,
  input  logic              lrck,
  input  logic              sdata,
  input  logic [1:0]        wlen_sel,
  output logic [DATA_W-1:0] left_data,
  output logic              left_valid,
  output logic [DATA_W-1:0] right_data,
  output logic              right_valid,
  output logic              frame_err
);
  localparam int unsigned CNT_W = $clog2(SLOT_BITS) + 1;

  logic              slot_edge;
  logic              chan_new;
  logic              chan_old;
  logic [CNT_W-1:0]  wl_q;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] word;

  lj_edge_det u_edge (
    .clk       (bclk),
    .rst       (rst),
    .lrck      (lrck),
    .slot_edge (slot_edge),
    .chan_new  (chan_new),
    .chan_old  (chan_old)
  );

  lj_wlen_latch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_wlen (
    .clk       (bclk),
    .rst       (rst),
    .slot_edge (slot_edge),
    .chan_new  (chan_new),
    .wlen_sel  (wlen_sel),
    .wl_o      (wl_q)
  );

  lj_slot_cap #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .clk       (bclk),
    .rst       (rst),
    .slot_edge (slot_edge),
    .sdata     (sdata),
    .wl_i      (wl_q),
    .active_o  (active),
    .cnt_o     (cnt),
    .word_o    (word)
  );

  lj_out_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk         (bclk),
    .rst         (rst),
    .slot_edge   (slot_edge),
    .active_i    (active),
    .chan_old    (chan_old),
    .cnt_i       (cnt),
    .wl_i        (wl_q),
    .word_i      (word),
    .left_data   (left_data),
    .left_valid  (left_valid),
    .right_data  (right_data),
    .right_valid (right_valid),
    .frame_err   (frame_err)
  );
endmodule

// File: rtl/lj_rx_chk.sv
module lj_rx_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 6
) (
  input logic              bclk,
  input logic              rst,
  input logic [CNT_W-1:0]  wl,
  input logic [DATA_W-1:0] left_data,
  input logic              left_valid,
  input logic [DATA_W-1:0] right_data,
  input logic              right_valid,
  input logic              frame_err
);
  logic [DATA_W-1:0] low_mask;
  assign low_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << (DATA_W - int'(wl))) - 1'b1;

  p_chan_excl_r2: assert property (@(posedge bclk) disable iff (rst)
    !(left_valid && right_valid));

  p_left_pulse_r7: assert property (@(posedge bclk) disable iff (rst)
    left_valid |=> !left_valid);

  p_right_pulse_r7: assert property (@(posedge bclk) disable iff (rst)
    right_valid |=> !right_valid);

  p_err_no_valid_r8: assert property (@(posedge bclk) disable iff (rst)
    frame_err |-> !left_valid && !right_valid);

  p_err_hold_r8: assert property (@(posedge bclk) disable iff (rst)
    frame_err |-> $stable(left_data) && $stable(right_data));

  p_left_mask_r5: assert property (@(posedge bclk) disable iff (rst)
    left_valid |-> (left_data & low_mask) == '0);
endmodule

bind lj_rx lj_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .bclk        (bclk),
  .rst         (rst),
  .wl          (wl_q),
  .left_data   (left_data),
  .left_valid  (left_valid),
  .right_data  (right_data),
  .right_valid (right_valid),
  .frame_err   (frame_err)
);

// File: tb/test_lj_rx.sv
`timescale 1ns/1ps
module test_lj_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  wlen_sel = 2'd2;
  logic [23:0] left_data, right_data;
  logic        left_valid, right_valid, frame_err;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 error, 1 left, 2 right
    logic [23:0] data;
    string       req;
  } exp_t;
  exp_t q[$];

  logic [23:0] last_l = '0, last_r = '0;
  int          wl_b = 24;
  bit          first = 1;

  always #4 clk = ~clk;

  lj_rx i_lj_rx (
    .bclk(clk), .rst(rst), .lrck(lrck), .sdata(sdata), .wlen_sel(wlen_sel),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : 24;
  endfunction

  // Drive one slot and queue what its closing must report.
  task automatic send(input logic lr, input logic [31:0] w, input int n,
                      input bit expect_it, input string req);
    exp_t e;
    logic [23:0] m;
    if (lr || first) begin
      wl_b  = len_of(wlen_sel);
      first = 0;
    end
    if (expect_it) begin
      m = ~((24'd1 << (24 - wl_b)) - 24'd1);
      e.req = req;
      if (n < wl_b) begin
        e.kind = 0;
        e.data = '0;
      end else begin
        e.kind = lr ? 1 : 2;
        e.data = w[31:8] & m;
      end
      q.push_back(e);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lrck  = lr;
      sdata = (i < 32) ? w[31-i] : 1'b1;
    end
  endtask

  // Monitor: outputs change on rising edges, read them on falling edges.
  always @(negedge clk) begin
    if (!rst && !done && (left_valid || right_valid || frame_err)) begin
      exp_t e;
      pulses++;
      check(!(left_valid && right_valid), "R2 both valid", {31'd0, left_valid}, 0);
      if (q.size() == 0) begin
        check(0, "R10 unexpected strobe", {29'd0, frame_err, right_valid, left_valid}, 0);
      end else begin
        e = q.pop_front();
        if (e.kind == 0) begin
          check(frame_err && !left_valid && !right_valid, {e.req, " R8 error strobe"},
                {29'd0, frame_err, right_valid, left_valid}, 32'd4);
          check(left_data == last_l && right_data == last_r, {e.req, " R8 data held"},
                {8'd0, left_data}, {8'd0, last_l});
        end else if (e.kind == 1) begin
          check(left_valid && !frame_err, {e.req, " R2 left strobe"},
                {29'd0, frame_err, right_valid, left_valid}, 32'd1);
          check(left_data == e.data, {e.req, " left data"}, {8'd0, left_data}, {8'd0, e.data});
          last_l = e.data;
        end else begin
          check(right_valid && !frame_err, {e.req, " R2 right strobe"},
                {29'd0, frame_err, right_valid, left_valid}, 32'd2);
          check(right_data == e.data, {e.req, " right data"}, {8'd0, right_data}, {8'd0, e.data});
          last_r = e.data;
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(left_data == 0 && right_data == 0, "R1 reset data", {8'd0, left_data}, 0);
    check(!left_valid && !right_valid && !frame_err, "R1 reset strobes",
          {29'd0, frame_err, right_valid, left_valid}, 0);
    rst = 1'b0;
    // R10: slot in progress at reset, ones on data, must stay silent
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sdata = 1'b1;
    end
    check(pulses == 0, "R10 silent before first edge", pulses, 0);
    check(left_data == 0, "R1 data still clear", {8'd0, left_data}, 0);

    wlen_sel = 2'd2;
    send(1, 32'hA5C3_F17E, 32, 1, "R4 24-bit left");
    wlen_sel = 2'd0;   // R9: mid-frame change, right slot keeps 24
    send(0, 32'h3C96_0F5A, 32, 1, "R9 right keeps 24");
    send(1, 32'hFFFF_FFFF, 32, 1, "R6 16-bit trailing ones");
    wlen_sel = 2'd1;
    send(0, 32'h1234_5678, 32, 1, "R9 right keeps 16");
    send(1, 32'h8000_0000, 32, 1, "R3 lone MSB");
    send(0, 32'h0F0F_0F0F, 32, 1, "R5 20-bit mask");
    wlen_sel = 2'd0;
    send(1, 32'hFFFF_FFFF, 10, 1, "R8 short left");
    send(0, 32'hBEEF_0000, 16, 1, "R5 exact 16");
    wlen_sel = 2'd3;
    send(1, 32'hDEAD_BEEF, 40, 1, "R11 long slot code3");
    send(0, 32'h1357_9BDF, 24, 1, "R7 exact 24");
    wlen_sel = 2'd2;
    send(1, 32'hFFFF_FFFF, 23, 1, "R8 short 24");
    send(0, 32'h0000_0000, 8, 0, "close");
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R7 all slots reported", q.size(), 0);
    check(!left_valid && !right_valid && !frame_err, "R7 strobes end",
          {29'd0, frame_err, right_valid, left_valid}, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule